// File: doc/BRIEF.md
# Tone-Transition Carrier Detector

This block decides whether a real frequency-shift-keyed data stream is present on an audio receive path. It does not look at amplitude. An upstream tone comparator supplies a one-bit decision per sample: the decision is 1 when the high tone is stronger than the low tone. For each channel, the block runs a phase accumulator at the symbol rate. It then checks whether tone transitions land where a clean stream puts them, which is at the accumulator's zero crossing.

Each channel keeps a confidence count. The count rises quickly when a transition is well timed and drops slowly when a transition comes at the wrong time. The count is held between a floor and a ceiling, and it is compared with a threshold to give a per-channel detect flag. Several channels can run side by side, for example demodulators with different input equalisation. Their flags are ORed into one combined flag.

Top module: `tone_lock_detect`

## Requirements
- R1: A synchronous reset clears the phase accumulator, the stored previous tone and the confidence count to 0. All detect outputs then read 0.
- R2: The phase accumulator is a 32-bit signed register. It advances by 2^29 on every strobe and wraps modulo 2^32, so one symbol is 8 strobes. A transition counts as well timed when the absolute value of the accumulator after that strobe's advance is strictly below 2^29. In practice this happens when the transition falls a multiple of 8 strobes after the accumulator was last zeroed, and this holds across the signed wrap.
- R3: A tone transition is a strobe whose tone bit differs from the tone bit of the previous strobe. The tone bit is 1 for the high tone. After reset, the previous tone is taken as 0.
- R4: A well-timed transition adds 7 to the confidence count.
- R5: A mistimed transition subtracts 1 from the count, but only when the count is at least 1. The count never goes below 0.
- R6: Every transition zeroes the phase accumulator, whether it was well timed or mistimed.
- R7: After each update the count is clamped to at most 100.
- R8: A channel's detect flag is 1 exactly when its count is strictly greater than 30.
- R9: The combined flag is the OR of all channel detect flags.
- R10: State changes only on cycles where sampleValid is 1. The tone input is ignored on other cycles. Outputs are registered and change at the clock edge that takes the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | One-cycle strobe per input sample |
| toneBit | input | NUM_CH | Per-channel tone decision, 1 = high tone stronger |
| chDetect | output | NUM_CH | Per-channel carrier-detect flag |
| anyDetect | output | 1 | OR of all channel flags |

## Verification
Every result of a strobe, both per-channel flags and the combined flag, is due at the clock edge that samples the strobe. The bench drives each strobe at a falling edge, drops it at the next falling edge, and compares against its model there, exactly one edge later. The bench then holds a random number of idle cycles with the tone inputs scrambled and checks the flags again each cycle. This shows that nothing moves without a strobe. The count is not visible at the ports, so its floor, threshold and ceiling are exposed by directed runs of well-timed and mistimed transitions. Each run is arranged so that the flag flips on one predicted strobe.

// File: rtl/tld_pkg.sv
package tld_pkg;

  // Event strobes raised by the phase control for one channel on one sample.
  typedef struct packed {
    logic hit;   // tone transition inside the timing window
    logic miss;  // tone transition outside the timing window
  } tld_strobe_t;

endpackage

// File: rtl/tld_phase_ctrl.sv
module tld_phase_ctrl
  import tld_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int STEP_LOG2 = 29
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleValid,
  input  logic        toneBit,
  output tld_strobe_t stb
);

  localparam logic signed [ACC_W-1:0] STEP    = ACC_W'(1) << STEP_LOG2;
  localparam logic signed [ACC_W-1:0] NEGSTEP = -STEP;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] accNext;
  logic                    prevTone;
  logic                    toneChange;
  logic                    nearZero;

  // Advance wraps naturally at the register width.
  assign accNext    = acc + STEP;
  assign nearZero   = (accNext < STEP) && (accNext > NEGSTEP);
  assign toneChange = sampleValid && (toneBit != prevTone);

  always_comb begin
    stb.hit  = toneChange && nearZero;
    stb.miss = toneChange && !nearZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      prevTone <= 1'b0;
    end else if (sampleValid) begin
      prevTone <= toneBit;
      if (toneChange) acc <= '0;
      else            acc <= accNext;
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> ($stable(acc) && $stable(prevTone)));

  // R6
  change_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.hit || stb.miss) |=> (acc == '0));

  // R3
  event_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.hit, stb.miss}));

endmodule

// File: rtl/tld_conf_count.sv
module tld_conf_count
  import tld_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int INC    = 7,
  parameter int DEC    = 1,
  parameter int MAXCNT = 100,
  parameter int THRESH = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  tld_strobe_t stb,
  output logic        detect
);

  localparam int SW = CNT_W + 1;
  localparam logic [SW-1:0]    INC_W = SW'(INC);
  localparam logic [CNT_W-1:0] DEC_W = CNT_W'(DEC);
  localparam logic [SW-1:0]    MAX_W = SW'(MAXCNT);
  localparam logic [CNT_W-1:0] THR_W = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt;
  logic [SW-1:0]    sum;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    sum = {1'b0, cnt};
    if (stb.hit)                     sum = {1'b0, cnt} + INC_W;
    else if (stb.miss && cnt >= DEC_W) sum = {1'b0, cnt - DEC_W};
    if (sum > MAX_W) sum = MAX_W;
    cntNext = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      detect <= 1'b0;
    end else begin
      cnt    <= cntNext;
      detect <= cntNext > THR_W;
    end
  end

  // R7
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} <= MAX_W);

  // R8
  detect_level_chk: assert property (@(posedge clk) disable iff (rst)
    detect == (cnt > THR_W));

  // R5
  floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.miss && cnt == '0) |=> (cnt == '0));

  // R4
  hit_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.hit && ({1'b0, cnt} + INC_W <= MAX_W)) |=> ({1'b0, cnt} == {1'b0, $past(cnt)} + INC_W));

  // R10
  no_event_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb.hit && !stb.miss) |=> $stable(cnt));

endmodule

// File: rtl/tld_channel.sv
module tld_channel
  import tld_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int STEP_LOG2 = 29,
  parameter int CNT_W     = 8,
  parameter int INC       = 7,
  parameter int DEC       = 1,
  parameter int MAXCNT    = 100,
  parameter int THRESH    = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic sampleValid,
  input  logic toneBit,
  output logic detect
);

  tld_strobe_t stb;

  tld_phase_ctrl #(
    .ACC_W    (ACC_W),
    .STEP_LOG2(STEP_LOG2)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .toneBit    (toneBit),
    .stb        (stb)
  );

  tld_conf_count #(
    .CNT_W (CNT_W),
    .INC   (INC),
    .DEC   (DEC),
    .MAXCNT(MAXCNT),
    .THRESH(THRESH)
  ) u_count (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .detect(detect)
  );

endmodule

// File: rtl/tone_lock_detect.sv
module tone_lock_detect #(
  parameter int NUM_CH    = 2,
  parameter int ACC_W     = 32,
  parameter int STEP_LOG2 = 29,
  parameter int CNT_W     = 8,
  parameter int INC       = 7,
  parameter int DEC       = 1,
  parameter int MAXCNT    = 100,
  parameter int THRESH    = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [NUM_CH-1:0] toneBit,
  output logic [NUM_CH-1:0] chDetect,
  output logic              anyDetect
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tld_channel #(
      .ACC_W    (ACC_W),
      .STEP_LOG2(STEP_LOG2),
      .CNT_W    (CNT_W),
      .INC      (INC),
      .DEC      (DEC),
      .MAXCNT   (MAXCNT),
      .THRESH   (THRESH)
    ) u_chan (
      .clk        (clk),
      .rst        (rst),
      .sampleValid(sampleValid),
      .toneBit    (toneBit[g]),
      .detect     (chDetect[g])
    );
  end

  assign anyDetect = |chDetect;

  // R10
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> ($stable(chDetect) && $stable(anyDetect)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (chDetect == '0 && !anyDetect));

endmodule

// File: tb/tone_lock_detect_bench.sv
module tone_lock_detect_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;
  localparam int WATCHDOG   = 150000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sampleValid = 1'b0;
  logic [NCH-1:0] toneBit = '0;
  logic [NCH-1:0] chDetect;
  logic           anyDetect;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  int   mPhase [NCH];
  int   mCnt   [NCH];
  logic mPrev  [NCH];
  logic [NCH-1:0] tcur = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_lock_detect u_tone_lock_detect (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .toneBit    (toneBit),
    .chDetect   (chDetect),
    .anyDetect  (anyDetect)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic expDetect(int ch);
    return mCnt[ch] > 30;
  endfunction

  function automatic logic expAny();
    logic r = 1'b0;
    for (int c = 0; c < NCH; c++) r = r | expDetect(c);
    return r;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int c = 0; c < NCH; c++) check(tag, chDetect[c], expDetect(c), $sformatf("chDetect[%0d]", c));
    check("R9", anyDetect, expAny(), "anyDetect");
  endtask

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      mPhase[c] = 0; mCnt[c] = 0; mPrev[c] = 1'b0;
    end
    tcur = '0;
  endtask

  // Model of one strobe: phase counted in eighths of a symbol.
  task automatic modelStep(logic [NCH-1:0] t);
    for (int c = 0; c < NCH; c++) begin
      mPhase[c] = (mPhase[c] + 1) % 8;
      if (t[c] != mPrev[c]) begin
        if (mPhase[c] == 0) mCnt[c] = mCnt[c] + 7;
        else if (mCnt[c] >= 1) mCnt[c] = mCnt[c] - 1;
        if (mCnt[c] > 100) mCnt[c] = 100;
        mPhase[c] = 0;
      end
      mPrev[c] = t[c];
    end
  endtask

  task automatic strobe(logic [NCH-1:0] t, string tag);
    int gap;
    @(negedge clk);
    toneBit = t;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    toneBit = NCH'($urandom);
    modelStep(t);
    checkAll(tag);
    gap = $urandom % 3;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      toneBit = NCH'($urandom);
      checkAll("R10");
    end
  endtask

  task automatic nearRun(logic [NCH-1:0] mask, int n, string tag);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 7; i++) strobe(tcur, tag);
      tcur = tcur ^ mask;
      strobe(tcur, tag);
    end
  endtask

  task automatic farRun(logic [NCH-1:0] mask, int n, string tag);
    for (int k = 0; k < n; k++) begin
      strobe(tcur, tag);
      strobe(tcur, tag);
      tcur = tcur ^ mask;
      strobe(tcur, tag);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      toneBit = NCH'($urandom);
      @(negedge clk);
    end
    rst = 1'b0;
    sampleValid = 1'b0;
    toneBit = '0;
    modelReset();
    @(negedge clk);
    check("R1", chDetect[0], 1'b0, "chDetect[0] after reset");
    check("R1", chDetect[1], 1'b0, "chDetect[1] after reset");
    check("R1", anyDetect, 1'b0, "anyDetect after reset");
  endtask

  initial begin
    int runLeft [NCH];
    void'($urandom(32'd4242));
    modelReset();
    doReset();

    // R5: mistimed transitions at count 0 keep it at 0
    farRun(2'b01, 10, "R5");
    nearRun(2'b01, 4, "R5");
    check("R5", chDetect[0], 1'b0, "after 4 hits from floor");
    nearRun(2'b01, 1, "R8");
    check("R8", chDetect[0], 1'b1, "after 5 hits (35 > 30)");
    check("R4", chDetect[1], 1'b0, "idle channel unaffected");

    // R7: saturate, then 69 misses keep the flag, the 70th clears it
    nearRun(2'b01, 15, "R7");
    farRun(2'b01, 69, "R7");
    check("R7", chDetect[0], 1'b1, "after 69 misses from ceiling");
    farRun(2'b01, 1, "R7");
    check("R7", chDetect[0], 1'b0, "after 70 misses from ceiling (30)");

    // R1: mid-run reset clears state
    nearRun(2'b10, 6, "R9");
    check("R9", anyDetect, 1'b1, "combined flag from channel 1");
    doReset();

    // R2: transition 24 strobes after zero is well timed across the signed wrap
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 23; i++) strobe(tcur, "R2");
      tcur = tcur ^ 2'b01;
      strobe(tcur, "R2");
    end
    check("R2", chDetect[0], 1'b1, "five wrapped hits");
    doReset();

    // R6: a mistimed transition re-zeroes the phase, so 8 strobes later is a hit
    for (int k = 0; k < 5; k++) begin
      strobe(tcur, "R6"); strobe(tcur, "R6");
      tcur = tcur ^ 2'b11;
      strobe(tcur, "R6");
      for (int i = 0; i < 7; i++) strobe(tcur, "R6");
      tcur = tcur ^ 2'b11;
      strobe(tcur, "R6");
    end
    check("R6", chDetect[0], 1'b1, "hit after re-zero (count 31)");
    check("R6", chDetect[1], 1'b1, "hit after re-zero ch1");
    doReset();

    // R3: first strobe with tone 1 after reset is a transition (phase 1, mistimed)
    strobe(2'b01, "R3");
    tcur = 2'b01;
    nearRun(2'b01, 5, "R3");
    check("R3", chDetect[0], 1'b1, "hits counted from first transition");

    // Random mix of run lengths, mostly symbol-aligned
    for (int c = 0; c < NCH; c++) runLeft[c] = 1 + ($urandom % 12);
    for (int s = 0; s < 4000; s++) begin
      for (int c = 0; c < NCH; c++) begin
        runLeft[c]--;
        if (runLeft[c] == 0) begin
          tcur[c] = ~tcur[c];
          runLeft[c] = (($urandom % 10) < 7) ? 8 * (1 + ($urandom % 2)) : 1 + ($urandom % 12);
        end
      end
      strobe(tcur, "R4");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule